// File: doc/BRIEF.md
# Guest Entry Control Consistency Checker

This block decides whether a set of virtual-machine execution controls is self-consistent before a guest is allowed to start. It receives the primary and secondary control words, a 32-bit priority threshold, the page address used for interrupt-controller access virtualization, a 16-bit virtual processor tag, a 64-bit nested-paging root pointer, one byte taken from the virtual interrupt-controller page, a mask of supported memory types and the physical-address width.

A one-cycle `start` pulse captures every input into internal registers. The block then evaluates twelve rules, one per clock, in a fixed order, and stops at the first rule that fails. It raises `done` for one cycle, with `pass` and a 4-bit `err_code` naming the failing rule (0 when all rules hold). Both stay valid until the next result. Memory reads, the entry itself and any state loading are left to surrounding logic.

Top module: `vm_entry_ctl_check`

## Requirements
- R1: After reset, `done`, `busy`, `pass` and `err_code` are all 0.
- R2: Control bit encoding: primary bit 0 = NMI exiting, bit 1 = virtual NMIs, bit 2 = NMI-window exiting, bit 3 = priority shadow, bit 4 = processor-tag enable, bit 31 = secondary word active. Secondary bit 0 = interrupt-controller access virtualization, bit 1 = extended interrupt-controller mode virtualization, bit 2 = nested paging. When primary bit 31 is 0, all three secondary enables are treated as 0, whatever the secondary word holds.
- R3: With priority shadow set, threshold bits 31:4 that are not zero fail with code 1. With priority shadow set and access virtualization off, a threshold bits 3:0 value greater than bits 7:4 of the supplied page byte fails with code 2.
- R4: Virtual NMIs set while NMI exiting is clear fails with code 3. NMI-window exiting set while virtual NMIs is clear fails with code 4.
- R5: With access virtualization on, a nonzero address bit 11:0 fails with code 5, and any set address bit at or above the effective physical-address width fails with code 6.
- R6: With extended-mode virtualization on, priority shadow clear or access virtualization on fails with code 7.
- R7: With the processor-tag enable set, a tag of 0000h fails with code 8.
- R8: With nested paging on, the root pointer fails with code 9 when the capability mask bit indexed by pointer bits 2:0 is 0, code 10 when bits 5:3 differ from 3, code 11 when bits 11:6 are not zero, and code 12 when any bit at or above the effective physical-address width is set.
- R9: Only the lowest-numbered failing rule is reported; `pass` is 1 exactly when `err_code` is 0.
- R10: `done` is high for exactly one cycle, k clock edges after the edge that accepted `start` when rule k fails, and 12 edges after it when all rules hold.
- R11: While `busy` is high, `start` is ignored and input changes have no effect on the running result.
- R12: The physical-address width is clamped to the range 32 to 52 before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check sequence (ignored while busy) |
| prim_ctl | input | 32 | Primary control word |
| sec_ctl | input | 32 | Secondary control word |
| prio_thresh | input | 32 | Priority threshold field |
| apic_page | input | 64 | Interrupt-controller access page address |
| vproc_tag | input | 16 | Virtual processor tag |
| npt_root | input | 64 | Nested-paging root pointer |
| vapic_byte | input | 8 | Byte from offset 80h of the virtual interrupt-controller page |
| mtype_cap | input | 8 | Supported memory-type mask, one bit per type |
| pa_width | input | 7 | Physical-address width |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | All rules held |
| err_code | output | 4 | First failing rule, 0 if none |

## Verification
The bench builds the block with its default width bounds of 32 and 52, so a width input of 10 or 60 lands on the clamp and the address rules can be probed right at bits 31, 32, 51 and 52. The fixed twelve-rule order keeps every sequence under 13 cycles, which lets several hundred random configurations, each with a fault injected in a random field, run alongside directed cases for every code, the gating of the secondary word and a start pulse arriving mid-sequence.

// File: rtl/vm_entry_ctl_check.sv
module vm_entry_ctl_check #(
  parameter int PA_MIN = 32,
  parameter int PA_MAX = 52,
  parameter int ADDR_W = 64,
  parameter int TAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       prim_ctl,
  input  logic [31:0]       sec_ctl,
  input  logic [31:0]       prio_thresh,
  input  logic [ADDR_W-1:0] apic_page,
  input  logic [TAG_W-1:0]  vproc_tag,
  input  logic [ADDR_W-1:0] npt_root,
  input  logic [7:0]        vapic_byte,
  input  logic [7:0]        mtype_cap,
  input  logic [6:0]        pa_width,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [3:0]        err_code
);
  localparam int NRULE = 12;
  localparam int PW_W  = 7;

  logic [31:0]       r_prim, r_sec, r_thr;
  logic [ADDR_W-1:0] r_page, r_root;
  logic [TAG_W-1:0]  r_tag;
  logic [7:0]        r_vbyte, r_cap;
  logic [PW_W-1:0]   r_pa;
  logic [3:0]        step;

  logic [PW_W-1:0] pa_clamped;
  assign pa_clamped = (int'(pa_width) < PA_MIN) ? PW_W'(PA_MIN) :
                      (int'(pa_width) > PA_MAX) ? PW_W'(PA_MAX) : pa_width;

  logic nmi_exit, vnmi, nmi_win, tpr_sh, tag_en, sec_on;
  logic acc_virt, x2_virt, npt_en;
  assign nmi_exit = r_prim[0];
  assign vnmi     = r_prim[1];
  assign nmi_win  = r_prim[2];
  assign tpr_sh   = r_prim[3];
  assign tag_en   = r_prim[4];
  assign sec_on   = r_prim[31];
  assign acc_virt = sec_on & r_sec[0];
  assign x2_virt  = sec_on & r_sec[1];
  assign npt_en   = sec_on & r_sec[2];

  logic [ADDR_W-1:0] hi_mask;
  assign hi_mask = ~((ADDR_W'(1) << r_pa) - ADDR_W'(1));

  logic [NRULE:0] fail;
  assign fail[0]  = 1'b0;
  assign fail[1]  = tpr_sh & (r_thr[31:4] != '0);
  assign fail[2]  = tpr_sh & ~acc_virt & (r_thr[3:0] > r_vbyte[7:4]);
  assign fail[3]  = vnmi & ~nmi_exit;
  assign fail[4]  = nmi_win & ~vnmi;
  assign fail[5]  = acc_virt & (r_page[11:0] != '0);
  assign fail[6]  = acc_virt & ((r_page & hi_mask) != '0);
  assign fail[7]  = x2_virt & (~tpr_sh | acc_virt);
  assign fail[8]  = tag_en & (r_tag == '0);
  assign fail[9]  = npt_en & ~r_cap[r_root[2:0]];
  assign fail[10] = npt_en & (r_root[5:3] != 3'd3);
  assign fail[11] = npt_en & (r_root[11:6] != '0);
  assign fail[12] = npt_en & ((r_root & hi_mask) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; pass <= 1'b0; err_code <= '0; step <= '0;
      r_prim <= '0; r_sec <= '0; r_thr <= '0; r_page <= '0; r_root <= '0;
      r_tag <= '0; r_vbyte <= '0; r_cap <= '0; r_pa <= PW_W'(PA_MIN);
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; step <= 4'd1;
          r_prim <= prim_ctl; r_sec <= sec_ctl; r_thr <= prio_thresh;
          r_page <= apic_page; r_root <= npt_root; r_tag <= vproc_tag;
          r_vbyte <= vapic_byte; r_cap <= mtype_cap; r_pa <= pa_clamped;
        end
      end else if (fail[step]) begin
        busy <= 1'b0; done <= 1'b1; pass <= 1'b0; err_code <= step;
      end else if (int'(step) == NRULE) begin
        busy <= 1'b0; done <= 1'b1; pass <= 1'b1; err_code <= '0;
      end else begin
        step <= step + 4'd1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R10
  AST_PASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass == (err_code == 4'd0))); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (int'(err_code) <= NRULE)); // R9
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(r_prim) && $stable(r_root) && $stable(r_page))); // R11
  AST_PA_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (int'(r_pa) >= PA_MIN) && (int'(r_pa) <= PA_MAX)); // R12
endmodule

// File: tb/vm_entry_ctl_check_tb.sv
module vm_entry_ctl_check_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] prim_ctl = '0, sec_ctl = '0, prio_thresh = '0;
  logic [63:0] apic_page = '0, npt_root = '0;
  logic [15:0] vproc_tag = '0;
  logic [7:0]  vapic_byte = '0, mtype_cap = '0;
  logic [6:0]  pa_width = 7'd32;
  logic busy, done, pass;
  logic [3:0] err_code;
  int checks = 0, failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vm_entry_ctl_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prim_ctl(prim_ctl), .sec_ctl(sec_ctl),
    .prio_thresh(prio_thresh), .apic_page(apic_page), .vproc_tag(vproc_tag),
    .npt_root(npt_root), .vapic_byte(vapic_byte), .mtype_cap(mtype_cap),
    .pa_width(pa_width), .busy(busy), .done(done), .pass(pass), .err_code(err_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [31:0] p, s, t, input logic [63:0] a,
      input logic [15:0] v, input logic [63:0] e, input logic [7:0] vb, cap, input logic [6:0] pw);
    int n;
    logic [63:0] hm;
    logic av, xv, np;
    n = (pw < 7'd32) ? 32 : (pw > 7'd52) ? 52 : int'(pw);
    hm = ~((64'd1 << n) - 64'd1);
    av = p[31] & s[0]; xv = p[31] & s[1]; np = p[31] & s[2];
    if (p[3] && t[31:4] != 0) return 1;
    if (p[3] && !av && t[3:0] > vb[7:4]) return 2;
    if (p[1] && !p[0]) return 3;
    if (p[2] && !p[1]) return 4;
    if (av && a[11:0] != 0) return 5;
    if (av && (a & hm) != 0) return 6;
    if (xv && (!p[3] || av)) return 7;
    if (p[4] && v == 0) return 8;
    if (np && !cap[e[2:0]]) return 9;
    if (np && e[5:3] != 3'd3) return 10;
    if (np && e[11:6] != 0) return 11;
    if (np && (e & hm) != 0) return 12;
    return 0;
  endfunction

  task automatic apply(input logic [31:0] p, s, t, input logic [63:0] a,
      input logic [15:0] v, input logic [63:0] e, input logic [7:0] vb, cap, input logic [6:0] pw);
    prim_ctl = p; sec_ctl = s; prio_thresh = t; apic_page = a; vproc_tag = v;
    npt_root = e; vapic_byte = vb; mtype_cap = cap; pa_width = pw;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (lat < 100) begin
      @(negedge clk); lat++;
      if (done) break;
    end
  endtask

  task automatic run(input string req, input logic [31:0] p, s, t, input logic [63:0] a,
      input logic [15:0] v, input logic [63:0] e, input logic [7:0] vb, cap, input logic [6:0] pw);
    int lat, ex;
    ex = exp_code(p, s, t, a, v, e, vb, cap, pw);
    apply(p, s, t, a, v, e, vb, cap, pw);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(lat);
    chk(done && int'(err_code) == ex, req, int'(err_code), ex);
    chk(pass == (ex == 0), {req, " R9 pass"}, int'(pass), int'(ex == 0));
    chk(lat == ((ex == 0) ? 12 : ex), {req, " R10 latency"}, lat, (ex == 0) ? 12 : ex);
    @(negedge clk);
    chk(!done, {req, " R10 pulse"}, int'(done), 0);
  endtask

  localparam logic [31:0] GP = 32'h8000_001F;
  localparam logic [31:0] GS = 32'h0000_0005;
  localparam logic [63:0] GA = 64'h0000_0001_2345_6000;
  localparam logic [63:0] GE = 64'h0000_0012_3456_701E;

  initial begin
    int lat;
    logic [31:0] p, s, t;
    logic [63:0] a, e;
    logic [15:0] v;
    logic [7:0] vb, cap;
    logic [6:0] pw;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !pass && err_code == 0, "R1 reset", int'({done, busy, pass, err_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R9 all good", GP, GS, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R3 code1", GP, GS, 32'h15, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R3 code2", GP, 32'h4, 32'h9, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R3 equal ok", GP, 32'h4, 32'h8, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R4 code3", GP & ~32'h1, GS, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R4 code4", GP & ~32'h2, GS, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R5 code5", GP, GS, 32'h5, GA | 64'h800, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R5 code6", GP, GS, 32'h5, GA | (64'd1 << 40), 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R6 code7", GP, 32'h7, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R6 x2 ok", GP, 32'h6, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R7 code8", GP, GS, 32'h5, GA, 16'h0, GE, 8'h80, 8'h41, 7'd40);
    run("R8 code9", GP, GS, 32'h5, GA, 16'h1, GE & ~64'h7 | 64'h1, 8'h80, 8'h41, 7'd40);
    run("R8 code10", GP, GS, 32'h5, GA, 16'h1, GE & ~64'h38 | 64'h20, 8'h80, 8'h41, 7'd40);
    run("R8 code11", GP, GS, 32'h5, GA, 16'h1, GE | 64'h40, 8'h80, 8'h41, 7'd40);
    run("R8 code12", GP, GS, 32'h5, GA, 16'h1, GE | (64'd1 << 45), 8'h80, 8'h41, 7'd40);
    run("R9 first of many", GP & ~32'h3, GS, 32'hF5, GA | 64'h1, 16'h0, 64'h0, 8'h80, 8'h00, 7'd40);
    run("R2 gated off", GP & ~32'h8000_0000, 32'hFFFF_FFFF, 32'h5, 64'h1, 16'h1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 8'h00, 7'd40);
    run("R2 gated rule2", GP & ~32'h8000_0000, 32'h1, 32'h9, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    run("R12 low clamp bit31 ok", GP, GS, 32'h5, 64'h8000_0000, 16'h1, GE & 64'hFFF, 8'h80, 8'h41, 7'd10);
    run("R12 low clamp bit32", GP, GS, 32'h5, 64'h1_0000_0000, 16'h1, GE & 64'hFFF, 8'h80, 8'h41, 7'd10);
    run("R12 high clamp bit51 ok", GP, GS, 32'h5, GA, 16'h1, GE | (64'd1 << 51), 8'h80, 8'h41, 7'd60);
    run("R12 high clamp bit52", GP, GS, 32'h5, GA, 16'h1, GE | (64'd1 << 52), 8'h80, 8'h41, 7'd60);

    // R11: start and input changes during a running sequence are ignored
    apply(GP, GS, 32'h5, GA, 16'h1, GE, 8'h80, 8'h41, 7'd40);
    start = 1'b1; @(negedge clk); start = 1'b0;
    lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    apply(GP, GS, 32'hFF, GA, 16'h0, 64'h0, 8'h00, 8'h00, 7'd40);
    start = 1'b1; @(negedge clk); lat++; start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(done && err_code == 0 && pass, "R11 busy start ignored", int'(err_code), 0);
    chk(lat == 12, "R11 latency unchanged", lat, 12);

    for (int i = 0; i < 400; i++) begin
      p = GP; s = GS; t = 32'h5; a = GA; v = 16'h1; e = GE; vb = 8'h80; cap = 8'h41;
      pw = 7'($urandom_range(20, 63));
      a = a & ~64'hFFFF_FFFF_0000_0000; e = e & 64'hFFFF_FFFF;
      case ($urandom_range(0, 9))
        0: p = p ^ (32'd1 << $urandom_range(0, 4));
        1: p[31] = $urandom_range(0, 1);
        2: s = $urandom & 32'h7;
        3: t = ($urandom_range(0, 3) == 0) ? $urandom : $urandom_range(0, 15);
        4: vb = 8'($urandom);
        5: a = a ^ (64'd1 << $urandom_range(0, 63));
        6: v = 16'($urandom_range(0, 1));
        7: e = e ^ (64'd1 << $urandom_range(0, 63));
        8: cap = 8'($urandom);
        default: begin p = $urandom; s = $urandom; t = $urandom_range(0, 31); e = {$urandom, $urandom}; end
      endcase
      run("R9 random", p, s, t, a, v, e, vb, cap, pw);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule